// File: doc/BRIEF.md
# I2C Sink Output Port Register

This block is a two-wire bus slave that holds one 8-bit output register. Each bit of the register controls one open-drain sink output. A bus master writes a byte to set the outputs and reads the byte back to see their state. The block samples the SCL and SDA lines with a fast system clock. It drives SDA low through an open-drain enable, both to acknowledge and to send read data.

A written byte goes into a shadow register first. The output register takes that byte only when the master ends the transfer with a STOP. A START that arrives before the STOP throws the pending byte away. This holds for a repeated START and for a START in the middle of a byte. Each bit of `sink_en` is the pull-down enable for one external open-drain output stage.

Top module: `i2c_sink_port`

## Requirements
- R1: The slave address is the 7-bit value {4'b1100, dev_sel[2], dev_sel[1], dev_sel[0]}, sent MSB first. When the address matches, the slave acknowledges by holding SDA low (sda_oe = 1) through the ninth SCL clock.
- R2: The eighth bit of the address byte picks the direction: 0 writes the output register and 1 reads it.
- R3: In a write, the slave acknowledges the first data byte after the address. Every later byte in the same transfer gets no acknowledge and is discarded.
- R4: Register bit n drives sink_en[n]. A 1 enables the pull-down, so the pin sinks current and reads low. A 0 releases the pin to high impedance. For example, writing 0xC1 sets only sink_en[0], sink_en[6] and sink_en[7].
- R5: A written byte reaches sink_en only through a STOP. sink_en takes the new value on the 4th rising system clock edge after SDA rises while SCL is high. At no other time does it change, apart from reset.
- R6: A read shifts out the committed register value MSB first. sda_oe = 1 sends a 0 bit. If the master acknowledges, the same value is sent again. If the master does not acknowledge, the read ends.
- R7: While rst_n is low at a rising clock edge, the register clears to 0x00, all sinks turn off, and any pending write is dropped. After reset the register reads back 0x00.
- R8: A START at any point restarts address reception and discards any written byte that a STOP has not yet committed. This covers a repeated START and a START in the middle of a byte. A read after a repeated START returns the committed value.
- R9: When the address does not match, SDA stays released (no acknowledge). The slave then ignores the bus until the next START, and sink_en does not change.
- R10: Each of SCL and SDA passes through a two-flop synchronizer. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high, and it returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| dev_sel | input | 3 | Low three address bits, MSB at index 2 |
| sda_oe | output | 1 | 1 drives SDA low, 0 releases it |
| sink_en | output | 8 | Committed register; 1 = output sinking |

## Verification
The bench acts as a bus master. It runs writes, reads with and without a master acknowledge, a second data byte in one write, and an address meant for a different device. It also runs a repeated START between a write and a read, a START in the middle of a byte, a change of the address pins, and a reset while a write is still pending. A behavioural model predicts the committed value and the clock edge at which it takes effect, and the bench compares sink_en against it on every clock. This comparison shows whether the output follows the data acknowledge or waits for STOP. The read-after-repeated-START case shows whether a read returns the committed value or the uncommitted shadow byte.

// File: rtl/i2c_sink_pkg.sv
package i2c_sink_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } link_state_t;
endpackage

// File: rtl/i2c_sink_sync.sv
module i2c_sink_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign q[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '1;
    else        prev <= q;
  end

  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/i2c_sink_link.sv
module i2c_sink_link
  import i2c_sink_pkg::*;
#(
  parameter int          BW      = 8,
  parameter int          SEL_W   = 3,
  parameter logic [3:0]  ADDR_HI = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_rise,
  input  logic             sda_fall,
  input  logic [SEL_W-1:0] dev_sel,
  input  logic [BW-1:0]    cur_val,
  output logic             sda_oe,
  output logic             commit,
  output logic [BW-1:0]    shadow
);
  localparam int CW = $clog2(BW + 1);
  localparam logic [CW-1:0] FULL = CW'(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  link_state_t   state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] rx, tx;
  logic          rd, pending;
  logic          start_ev, stop_ev;
  logic [BW-2:0] my_addr;

  assign start_ev = scl & sda_fall;
  assign stop_ev  = scl & sda_rise;
  assign my_addr  = {ADDR_HI, dev_sel};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; rx <= '0; tx <= '0; rd <= 1'b0;
      pending <= 1'b0; sda_oe <= 1'b0; commit <= 1'b0; shadow <= '0;
    end else begin
      commit <= 1'b0;
      if (start_ev) begin
        state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; pending <= 1'b0;
      end else if (stop_ev) begin
        state <= ST_IDLE; sda_oe <= 1'b0; pending <= 1'b0;
        if (pending) commit <= 1'b1;
      end else begin
        case (state)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && cnt < FULL) begin
              rx  <= {rx[BW-2:0], sda};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == ST_WDATA) begin
                sda_oe <= 1'b1; shadow <= rx; pending <= 1'b1; state <= ST_WACK;
              end else if (rx[BW-1:1] == my_addr) begin
                sda_oe <= 1'b1; rd <= rx[0]; state <= ST_AACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rd) begin
              tx <= cur_val; sda_oe <= ~cur_val[BW-1]; state <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0; state <= ST_WDATA;
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_oe <= 1'b0; state <= ST_SKIP;
          end
          ST_RDATA: if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0; state <= ST_RACK;
            end else begin
              sda_oe <= ~tx[BW-2]; tx <= tx << 1; cnt <= cnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise && sda) state <= ST_SKIP;
            else if (scl_fall) begin
              tx <= cur_val; sda_oe <= ~cur_val[BW-1]; cnt <= '0; state <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: a START always reopens address reception
  a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> state == ST_ADDR);
  // R10: a STOP returns the link to idle
  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> state == ST_IDLE);
  // R9: a foreign address is never acknowledged
  a_r9_no_foreign_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && scl_fall && cnt == FULL && rx[BW-1:1] != my_addr
     && !start_ev && !stop_ev) |=> !sda_oe);
  // R9: while idle or ignoring the bus, SDA stays released
  a_r9_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe);
endmodule

// File: rtl/i2c_sink_port.sv
module i2c_sink_port #(
  parameter int         BW          = 8,
  parameter int         SEL_W       = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI     = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] dev_sel,
  output logic             sda_oe,
  output logic [BW-1:0]    sink_en
);
  logic [1:0]    ln_q, ln_rise, ln_fall;
  logic          commit;
  logic [BW-1:0] shadow;

  i2c_sink_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i}),
    .q(ln_q), .rise(ln_rise), .fall(ln_fall)
  );

  i2c_sink_link #(.BW(BW), .SEL_W(SEL_W), .ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(rst_n),
    .scl(ln_q[0]), .sda(ln_q[1]),
    .scl_rise(ln_rise[0]), .scl_fall(ln_fall[0]),
    .sda_rise(ln_rise[1]), .sda_fall(ln_fall[1]),
    .dev_sel(dev_sel), .cur_val(sink_en),
    .sda_oe(sda_oe), .commit(commit), .shadow(shadow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      sink_en <= '0;
    else if (commit) sink_en <= shadow;
  end

  // R5: the output register moves only on a STOP commit
  a_r5_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_en != $past(sink_en)) |-> $past(commit));

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= !rst_n;
  // R7: one edge after reset the outputs are all off
  always @(posedge clk) begin
    if (rst_seen) a_r7_reset_clears: assert (sink_en == '0);
  end
endmodule

// File: tb/sim_i2c_sink_port.sv
module sim_i2c_sink_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] sel = 3'b101;
  logic       sda_oe;
  logic [7:0] sink_en;
  wire        sda_bus = m_sda & ~sda_oe;

  int checks = 0, fails = 0;
  logic [7:0] exp_sink = 8'h00, pend_val = 8'h00, m_shadow = 8'h00;
  int  pend_cnt = 0;
  bit  m_valid = 1'b0, mon_on = 1'b0;

  always #10 clk = ~clk;

  i2c_sink_port u0 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
                    .dev_sel(sel), .sda_oe(sda_oe), .sink_en(sink_en));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // reference model: committed value and its due edge, compared every clock
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin exp_sink = 8'h00; pend_cnt = 0; end
    else if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) exp_sink = pend_val;
    end
    if (mon_on) chk(sink_en == exp_sink, "R5 per-clock sink_en", sink_en, exp_sink);
  end

  task automatic wq(); repeat (4) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    m_sda = 1'b0; m_valid = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq();
    m_sda = 1'b1;
    if (m_valid) begin pend_val = m_shadow; pend_cnt = 4; m_valid = 1'b0; end
    wq(); wq();
  endtask

  task automatic send_bit(input bit b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output bit b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic rd_byte(output logic [7:0] v, input bit mack);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!mack);
  endtask

  function automatic logic [7:0] abyte(input logic [2:0] s, input bit r);
    return {4'b1100, s, r};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ak;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; mon_on = 1'b1; wq();
    chk(sink_en == 8'h00, "R7 reset value", sink_en, 0);

    // write 0xC1, committed at STOP
    bus_start();
    wr_byte(abyte(3'b101, 1'b0), ak); chk(ak, "R1 address ack", ak, 1);
    wr_byte(8'hC1, ak); chk(ak, "R3 data ack", ak, 1);
    m_shadow = 8'hC1; m_valid = 1'b1;
    chk(sink_en == 8'h00, "R5 no change before STOP", sink_en, 0);
    bus_stop();
    chk(sink_en == 8'hC1, "R4 bits 0,6,7 sink", sink_en, 8'hC1);

    // read back with NACK
    bus_start();
    wr_byte(abyte(3'b101, 1'b1), ak); chk(ak, "R2 read address ack", ak, 1);
    rd_byte(v, 1'b0); chk(v == 8'hC1, "R6 read value", v, 8'hC1);
    bus_stop();

    // read with master ACK repeats the value
    bus_start();
    wr_byte(abyte(3'b101, 1'b1), ak);
    rd_byte(v, 1'b1); chk(v == 8'hC1, "R6 first read byte", v, 8'hC1);
    rd_byte(v, 1'b0); chk(v == 8'hC1, "R6 repeated read byte", v, 8'hC1);
    bus_stop();

    // second data byte not acknowledged
    bus_start();
    wr_byte(abyte(3'b101, 1'b0), ak);
    wr_byte(8'h5A, ak); chk(ak, "R3 first data ack", ak, 1);
    m_shadow = 8'h5A; m_valid = 1'b1;
    wr_byte(8'h77, ak); chk(!ak, "R3 extra byte nack", ak, 0);
    bus_stop();
    chk(sink_en == 8'h5A, "R3 first byte kept", sink_en, 8'h5A);

    // foreign address
    bus_start();
    wr_byte(abyte(3'b011, 1'b0), ak); chk(!ak, "R9 foreign address nack", ak, 0);
    wr_byte(8'h12, ak); chk(!ak, "R9 data ignored", ak, 0);
    bus_stop();
    chk(sink_en == 8'h5A, "R9 output unchanged", sink_en, 8'h5A);

    // repeated START: read gives committed value, pending write dropped
    bus_start();
    wr_byte(abyte(3'b101, 1'b0), ak);
    wr_byte(8'h3C, ak); m_shadow = 8'h3C; m_valid = 1'b1;
    bus_start();
    wr_byte(abyte(3'b101, 1'b1), ak); chk(ak, "R8 ack after repeated START", ak, 1);
    rd_byte(v, 1'b0); chk(v == 8'h5A, "R8 read returns committed", v, 8'h5A);
    bus_stop();
    chk(sink_en == 8'h5A, "R8 pending write discarded", sink_en, 8'h5A);

    // START in mid-byte aborts
    bus_start();
    wr_byte(abyte(3'b101, 1'b0), ak);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    wr_byte(abyte(3'b101, 1'b0), ak); chk(ak, "R8 ack after mid-byte START", ak, 1);
    wr_byte(8'h0F, ak); m_shadow = 8'h0F; m_valid = ak;
    bus_stop();
    chk(sink_en == 8'h0F, "R10 STOP commits", sink_en, 8'h0F);

    // address pins change
    sel = 3'b010; wq();
    bus_start();
    wr_byte(abyte(3'b101, 1'b0), ak); chk(!ak, "R1 old address rejected", ak, 0);
    bus_stop();
    bus_start();
    wr_byte(abyte(3'b010, 1'b0), ak); chk(ak, "R1 new address ack", ak, 1);
    wr_byte(8'h81, ak); m_shadow = 8'h81; m_valid = ak;
    bus_stop();
    chk(sink_en == 8'h81, "R1 write via new address", sink_en, 8'h81);

    // reset drops a pending write
    bus_start();
    wr_byte(abyte(3'b010, 1'b0), ak);
    wr_byte(8'hFF, ak); m_shadow = 8'hFF; m_valid = 1'b1;
    rst_n = 1'b0; m_valid = 1'b0; repeat (2) @(negedge clk);
    rst_n = 1'b1; wq();
    chk(sink_en == 8'h00, "R7 reset clears outputs", sink_en, 0);
    bus_stop();
    chk(sink_en == 8'h00, "R7 pending write dropped", sink_en, 0);
    bus_start();
    wr_byte(abyte(3'b010, 1'b1), ak);
    rd_byte(v, 1'b0); chk(v == 8'h00, "R7 reads zero after reset", v, 0);
    bus_stop();

    mon_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule